// File: doc/BRIEF.md
# Flash fast-program command sequencer

This block is the command interface of a parallel NOR-style flash memory model. It accepts bus write cycles and decodes two fast-program commands. In byte organisation, one setup cycle followed by eight data cycles programs eight bytes that lie in one aligned group of four words. In word organisation, one setup cycle followed by two data cycles programs two words that lie in one aligned pair. The address of every data cycle is checked against the group opened by the first data cycle. A stray address aborts the command with a sequence error.

The final data cycle hands the collected group to an internal program engine. The engine runs for a parameterised number of clock cycles and ANDs each collected value into a small on-chip array, so bits can only go from 1 to 0. While it runs, bus reads return a status word that shows the device busy, and bus writes are ignored. A clean finish puts the device back in array read mode by itself. A failed or malformed program leaves the status word on the bus until a reset command is written.

Top module: `flashseq_top`

## Requirements
- R1: After reset, every array word reads 0xFFFF and the device is in array read mode.
- R2: With word_mode=0, a write whose wr_data[7:0] equals CMD_OCT (0x80) opens an eight-byte command. Each of the next eight writes stores wr_data[7:0] into the byte selected by wr_addr (word) and wr_bsel (1 = bits 15:8, 0 = bits 7:0). wr_data[15:8] is ignored. The eighth write starts programming.
- R3: In an eight-byte command, all eight word addresses must agree above bit 1. In a two-word command, both must agree above bit 0. Any mismatch, detected by the final data write, leaves the array unchanged and enters the error state with status 0x0090.
- R4: With word_mode=1, a write with code CMD_DUO (0x50) opens a two-word command. Each of the next two writes stores all 16 bits of wr_data at word wr_addr, and the second write starts programming.
- R5: Programming lasts exactly PROG_CYCLES clock cycles. During that time, reads return status 0x0000 (bit 7 = ready is 0) and all bus writes are ignored.
- R6: Each programmed location becomes its old value ANDed with the new data. After a clean finish, the device returns to array read mode without any command.
- R7: A 1 written over a stored 0 in any programmed location is a program failure. The array still receives the AND, and the device enters the error state with status 0x00A0 (bit 7 ready, bit 5 program fail).
- R8: In the error state, every read returns the status word and every write other than CMD_RST (0xF0) is ignored. A CMD_RST write clears the error flags and restores array read mode.
- R9: In read mode, a write with an unrecognised code, or a command code issued in the wrong organisation (0x80 with word_mode=1, 0x50 with word_mode=0), has no effect. CMD_RST in read mode also has no effect.
- R10: rd_data is registered, with one cycle of latency from rd_addr. In read mode with word_mode=1, it returns the whole word. With word_mode=0, it returns the byte picked by rd_bsel in bits 7:0, with bits 15:8 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1 = word organisation, 0 = byte organisation |
| wr_en | input | 1 | Bus write strobe, one cycle per bus write |
| wr_addr | input | WORD_AW | Word address of a bus write |
| wr_bsel | input | 1 | Byte select of a bus write in byte mode |
| wr_data | input | 16 | Bus write data; the command code is in bits 7:0 |
| rd_addr | input | WORD_AW | Word address for reads |
| rd_bsel | input | 1 | Byte select for reads in byte mode |
| rd_data | output | 16 | Registered read data: array contents or status |

## Verification
The bench sweeps two-word programs over every aligned pair and eight-byte programs over every group. It feeds the bytes in several permuted orders, so a design that placed a byte by its arrival slot instead of its address would corrupt the array. The busy window is sampled cycle by cycle, which exposes an engine that is one cycle short or long, or one that shows the fail flag early. A command written in the middle of programming is shown to be ignored, because a design that obeyed it would leave reads stuck on status. The bench also covers a last-byte address outside the group, a 1 written over a stored 0, and commands issued in the wrong organisation. In each case a flawed design would either alter the array or fail to hold, or to release, the sticky status until the reset code.

// File: rtl/flashseq_pkg.sv
package flashseq_pkg;
  typedef enum logic [1:0] {
    ST_READ = 2'd0,
    ST_COLL = 2'd1,
    ST_BUSY = 2'd2,
    ST_ERR  = 2'd3
  } seq_state_e;

  localparam int GRP_WORDS   = 4;
  localparam int STAT_READY  = 7;
  localparam int STAT_PFAIL  = 5;
  localparam int STAT_SEQERR = 4;
endpackage

// File: rtl/flashseq_collect.sv
module flashseq_collect
  import flashseq_pkg::*;
#(
  parameter int WORD_AW = 4,
  parameter int DW      = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  input  logic                               mode_w,
  input  logic                               dat_we,
  input  logic [WORD_AW-1:0]                 addr,
  input  logic                               bsel,
  input  logic [DW-1:0]                      data,
  output logic [GRP_WORDS-1:0][DW-1:0]       buf_q,
  output logic [GRP_WORDS-1:0][DW-1:0]       msk_q,
  output logic [WORD_AW-1:0]                 grp_q,
  output logic                               is_last,
  output logic                               seq_bad
);
  localparam int HW = DW / 2;

  logic [3:0]         cnt;
  logic               bad_q;
  logic [WORD_AW-1:0] grp_now;
  logic [1:0]         slot;
  logic [3:0]         need;

  assign grp_now = mode_w ? {addr[WORD_AW-1:1], 1'b0} : {addr[WORD_AW-1:2], 2'b00};
  assign slot    = mode_w ? {1'b0, addr[0]} : addr[1:0];
  assign need    = mode_w ? 4'd2 : 4'd8;
  assign is_last = dat_we && (cnt == need - 4'd1);
  assign seq_bad = bad_q || (dat_we && cnt != 4'd0 && grp_now != grp_q);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt   <= '0;
      bad_q <= 1'b0;
      grp_q <= '0;
      for (int i = 0; i < GRP_WORDS; i++) begin
        buf_q[i] <= '1;
        msk_q[i] <= '0;
      end
    end else if (dat_we) begin
      cnt   <= cnt + 4'd1;
      bad_q <= seq_bad;
      if (cnt == 4'd0) grp_q <= grp_now;
      if (mode_w) begin
        buf_q[slot] <= data;
        msk_q[slot] <= '1;
      end else if (bsel) begin
        buf_q[slot][DW-1:HW] <= data[HW-1:0];
        msk_q[slot][DW-1:HW] <= '1;
      end else begin
        buf_q[slot][HW-1:0] <= data[HW-1:0];
        msk_q[slot][HW-1:0] <= '1;
      end
    end
  end
endmodule

// File: rtl/flashseq_array.sv
module flashseq_array #(
  parameter int WORD_AW = 4,
  parameter int DW      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pg_en,
  input  logic [WORD_AW-1:0] pg_addr,
  input  logic [DW-1:0]      pg_new,
  input  logic [DW-1:0]      pg_mask,
  output logic               pg_fail,
  input  logic [WORD_AW-1:0] rd_addr,
  output logic [DW-1:0]      rd_word
);
  localparam int DEPTH = 1 << WORD_AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] old_w;

  assign old_w   = mem[pg_addr];
  assign pg_fail = pg_en && ((~old_w & pg_new & pg_mask) != '0);
  assign rd_word = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (pg_en) begin
      mem[pg_addr] <= old_w & pg_new;
    end
  end
endmodule

// File: rtl/flashseq_top.sv
module flashseq_top
  import flashseq_pkg::*;
#(
  parameter int         WORD_AW     = 4,
  parameter int         PROG_CYCLES = 6,
  parameter logic [7:0] CMD_OCT     = 8'h80,
  parameter logic [7:0] CMD_DUO     = 8'h50,
  parameter logic [7:0] CMD_RST     = 8'hF0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_mode,
  input  logic               wr_en,
  input  logic [WORD_AW-1:0] wr_addr,
  input  logic               wr_bsel,
  input  logic [15:0]        wr_data,
  input  logic [WORD_AW-1:0] rd_addr,
  input  logic               rd_bsel,
  output logic [15:0]        rd_data
);
  localparam int DW = 16;
  localparam int CW = $clog2(PROG_CYCLES + 1);

  seq_state_e state;
  logic       mode_q, fail_q, seq_q;
  logic [CW-1:0] bcnt;
  logic [7:0] code;
  logic       start, dat_we, is_last, seq_bad, pg_en, pg_fail;
  logic [CW-1:0] nwords;
  logic [GRP_WORDS-1:0][DW-1:0] buf_q, msk_q;
  logic [WORD_AW-1:0] grp_q, pg_addr;
  logic [DW-1:0] rd_word, status;

  assign code   = wr_data[7:0];
  assign start  = (state == ST_READ) && wr_en &&
                  ((code == CMD_OCT && !word_mode) || (code == CMD_DUO && word_mode));
  assign dat_we = (state == ST_COLL) && wr_en;
  assign nwords = mode_q ? CW'(2) : CW'(4);
  assign pg_en  = (state == ST_BUSY) && (bcnt < nwords);
  assign pg_addr = grp_q | WORD_AW'(bcnt[1:0]);

  flashseq_collect #(.WORD_AW(WORD_AW), .DW(DW)) u_collect (
    .clk(clk), .rst(rst), .start(start), .mode_w(mode_q), .dat_we(dat_we),
    .addr(wr_addr), .bsel(wr_bsel), .data(wr_data),
    .buf_q(buf_q), .msk_q(msk_q), .grp_q(grp_q),
    .is_last(is_last), .seq_bad(seq_bad)
  );

  flashseq_array #(.WORD_AW(WORD_AW), .DW(DW)) u_array (
    .clk(clk), .rst(rst), .pg_en(pg_en), .pg_addr(pg_addr),
    .pg_new(buf_q[bcnt[1:0]]), .pg_mask(msk_q[bcnt[1:0]]), .pg_fail(pg_fail),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  always_comb begin
    status = '0;
    status[STAT_READY]  = (state != ST_BUSY);
    status[STAT_PFAIL]  = fail_q && (state != ST_BUSY);
    status[STAT_SEQERR] = seq_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_READ;
      mode_q <= 1'b0;
      fail_q <= 1'b0;
      seq_q  <= 1'b0;
      bcnt   <= '0;
    end else begin
      case (state)
        ST_READ: if (start) begin
          state  <= ST_COLL;
          mode_q <= word_mode;
          fail_q <= 1'b0;
          seq_q  <= 1'b0;
        end
        ST_COLL: if (is_last) begin
          bcnt <= '0;
          if (seq_bad) begin
            state <= ST_ERR;
            seq_q <= 1'b1;
          end else begin
            state <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          fail_q <= fail_q || pg_fail;
          bcnt   <= bcnt + CW'(1);
          if (bcnt == CW'(PROG_CYCLES - 1))
            state <= (fail_q || pg_fail) ? ST_ERR : ST_READ;
        end
        default: if (wr_en && code == CMD_RST) begin
          state  <= ST_READ;
          fail_q <= 1'b0;
          seq_q  <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (state != ST_READ) rd_data <= status;
    else if (word_mode) rd_data <= rd_word;
    else rd_data <= {8'h00, rd_bsel ? rd_word[15:8] : rd_word[7:0]};
  end
endmodule

// File: rtl/flashseq_chk.sv
module flashseq_chk
  import flashseq_pkg::*;
#(
  parameter int         PROG_CYCLES = 6,
  parameter logic [7:0] CMD_OCT     = 8'h80,
  parameter logic [7:0] CMD_RST     = 8'hF0
) (
  input logic        clk,
  input logic        rst,
  input logic        word_mode,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input seq_state_e  st
);
  logic [15:0] bc;
  logic        prev_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      bc <= '0;
      prev_busy <= 1'b0;
    end else begin
      bc <= (st == ST_BUSY) ? bc + 16'd1 : 16'd0;
      prev_busy <= (st == ST_BUSY);
    end
  end

  assert_busy_max_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BUSY) |-> (bc < 16'(PROG_CYCLES)));

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (rst)
    (st != ST_BUSY && bc != 16'd0) |-> (bc == 16'(PROG_CYCLES)));

  assert_busy_status_R5: assert property (@(posedge clk) disable iff (rst)
    prev_busy |-> (rd_data == 16'h0000));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERR && !(wr_en && wr_data[7:0] == CMD_RST)) |=> (st == ST_ERR));

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERR && wr_en && wr_data[7:0] == CMD_RST) |=> (st == ST_READ));

  assert_wrong_mode_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_READ && wr_en && word_mode && wr_data[7:0] == CMD_OCT) |=> (st == ST_READ));
endmodule

bind flashseq_top flashseq_chk #(
  .PROG_CYCLES(PROG_CYCLES), .CMD_OCT(CMD_OCT), .CMD_RST(CMD_RST)
) u_chk (
  .clk(clk), .rst(rst), .word_mode(word_mode), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .st(state)
);

// File: tb/flashseq_top_bench.sv
module flashseq_top_bench;
  localparam int AW = 4;
  localparam int NW = 1 << AW;
  localparam int PC = 6;

  logic clk = 1'b0, rst = 1'b1, word_mode = 1'b1, wr_en = 1'b0, wr_bsel = 1'b0, rd_bsel = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [15:0] exp_m [NW];
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  flashseq_top #(.WORD_AW(AW), .PROG_CYCLES(PC)) u_flashseq_top (
    .clk(clk), .rst(rst), .word_mode(word_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_bsel(wr_bsel), .wr_data(wr_data), .rd_addr(rd_addr), .rd_bsel(rd_bsel),
    .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic wr(input int a, input bit b, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_bsel = b; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input int a, input bit b, input logic [15:0] expv);
    @(negedge clk);
    rd_addr = AW'(a); rd_bsel = b;
    @(negedge clk);
    chk(tag, rd_data, expv);
  endtask

  task automatic dump(input string tag);
    word_mode = 1'b1;
    for (int a = 0; a < NW; a++) rd(tag, a, 1'b0, exp_m[a]);
  endtask

  // after the final data write: check each busy cycle, then the settled read
  task automatic wait_done(input string tag, input int a, input bit failed);
    word_mode = 1'b1; rd_addr = AW'(a);
    for (int k = 0; k < PC; k++) begin
      @(negedge clk);
      chk({tag, " busy status R5"}, rd_data, 16'h0000);
    end
    @(negedge clk);
    chk({tag, " after busy R6/R7"}, rd_data, failed ? 16'h00A0 : exp_m[a]);
  endtask

  function automatic bit fails(input logic [15:0] o, input logic [15:0] n, input logic [15:0] m);
    return ((~o & n & m) != 16'h0);
  endfunction

  task automatic do_duo(input int g, input logic [15:0] d0, input logic [15:0] d1,
                        input bit swap, input bit bad, output bit failed);
    int a0, a1;
    a0 = 2 * g; a1 = 2 * g + 1;
    failed = fails(exp_m[a0], d0, 16'hFFFF) || fails(exp_m[a1], d1, 16'hFFFF);
    word_mode = 1'b1;
    wr(0, 1'b0, 16'h0050);
    if (swap) begin
      wr(a1, 1'b0, d1);
      wr(bad ? (a0 + 2) % NW : a0, 1'b0, d0);
    end else begin
      wr(a0, 1'b0, d0);
      wr(bad ? (a1 + 2) % NW : a1, 1'b0, d1);
    end
    if (!bad) begin
      exp_m[a0] = exp_m[a0] & d0;
      exp_m[a1] = exp_m[a1] & d1;
    end
  endtask

  task automatic do_oct(input int g, input int x, input bit bad);
    word_mode = 1'b0;
    wr(0, 1'b0, 16'h0080);
    for (int i = 0; i < 8; i++) begin
      int j, w;
      bit h;
      logic [7:0] ob, nb;
      j = i ^ x; w = 4 * g + j / 2; h = j[0];
      ob = h ? exp_m[w][15:8] : exp_m[w][7:0];
      nb = ob & ~(8'd1 << ((g + j) % 8));
      wr((bad && i == 7) ? (w + 4) % NW : w, h, {8'h5A, nb});
      if (!bad) begin
        if (h) exp_m[w][15:8] = nb;
        else exp_m[w][7:0] = nb;
      end
    end
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit f;
    for (int a = 0; a < NW; a++) exp_m[a] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    dump("reset R1");

    // R4/R6: two-word program on every pair, alternating address order
    for (int g = 0; g < NW / 2; g++) begin
      do_duo(g, 16'hFFFF ^ (16'h0101 << (g % 8)), 16'h7FFE >> g, g[0], 1'b0, f);
      wait_done("duo R4", 2 * g, f);
      chk("duo no fail R6", 16'(f), 16'h0);
    end
    dump("duo sweep R4 R6");

    // R2/R6: eight-byte program on every group with permuted byte order
    for (int g = 0; g < NW / 4; g++) begin
      do_oct(g, (g * 3) % 8, 1'b0);
      wait_done("oct R2", 4 * g + 1, 1'b0);
    end
    dump("oct sweep R2 R6");

    // R10: byte reads in byte mode
    word_mode = 1'b0;
    for (int a = 0; a < 4; a++) begin
      rd("byte lo R10", a, 1'b0, {8'h00, exp_m[a][7:0]});
      rd("byte hi R10", a, 1'b1, {8'h00, exp_m[a][15:8]});
    end

    // R5: writes during busy are ignored
    do_oct(2, 5, 1'b0);
    word_mode = 1'b1;
    wr(0, 1'b0, 16'h0050);
    wr(0, 1'b0, 16'h00F0);
    repeat (PC) @(negedge clk);
    dump("busy ignores writes R5");

    // R3: byte group mismatch on the last byte
    do_oct(1, 2, 1'b1);
    rd("oct seq err R3", 0, 1'b0, 16'h0090);
    rd("oct seq err sticky R8", 9, 1'b0, 16'h0090);
    word_mode = 1'b0;
    wr(0, 1'b0, 16'h0080);
    rd("err ignores cmd R8", 3, 1'b0, 16'h0090);
    wr(0, 1'b0, 16'h00F0);
    dump("after oct seq err R3 R8");

    // R3: word pair mismatch
    do_duo(3, 16'h0000, 16'h0000, 1'b0, 1'b1, f);
    rd("duo seq err R3", 6, 1'b0, 16'h0090);
    wr(0, 1'b0, 16'h00F0);
    dump("after duo seq err R3");

    // R7: 1 over 0 fails, array still ANDed, sticky until reset
    do_duo(7, 16'h0F0F, 16'hC3FF, 1'b0, 1'b0, f);
    chk("fail expected R7", 16'(f), 16'h1);
    wait_done("duo fail R7", 14, f);
    rd("fail sticky R8", 2, 1'b0, 16'h00A0);
    wr(0, 1'b0, 16'h0050);
    rd("fail ignores cmd R8", 5, 1'b0, 16'h00A0);
    wr(0, 1'b0, 16'h00F0);
    dump("after fail R7 R8");

    // R9: wrong-organisation and unknown codes are ignored
    word_mode = 1'b1;
    wr(0, 1'b0, 16'h0080);
    wr(3, 1'b0, 16'h0000);
    dump("octal in word mode R9");
    word_mode = 1'b0;
    wr(0, 1'b0, 16'h0050);
    wr(4, 1'b0, 16'h0000);
    wr(5, 1'b0, 16'h0000);
    dump("duo in byte mode R9");
    word_mode = 1'b1;
    wr(0, 1'b0, 16'h0033);
    wr(1, 1'b0, 16'h0000);
    wr(0, 1'b0, 16'h00F0);
    dump("unknown code R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule